// File: doc/BRIEF.md
# Dual-Rate Down-Counting Interval Timer

This block is a countdown timer for a system-on-chip peripheral space. Software writes a load value, which becomes both the live count and the stored reload interval. It also writes an 8-bit control byte, which picks the tick rate, one-shot or auto-reload operation, and whether counting is on. Two free-running prescalers derive a slow tick (system clock divided down to 2 kHz) and a fast tick (system clock divided down to 512 kHz) from the system clock. The control byte picks which of the two ticks drives the counter.

Each selected tick decrements the count while counting is on. When a decrement reaches zero, the block raises a one-cycle interrupt pulse. In auto-reload mode the interval is copied back into the count at that moment. In one-shot mode the count rests at zero, and later ticks wrap it through all ones. A read port returns either the live count or the control byte. Address decoding and interrupt routing are done by the surrounding fabric.

Top module: `dual_rate_timer`

## Requirements
- R1: After reset the count is 0, the interrupt is low and the control byte reads back as 0.
- R2: A cycle with `load_we` high sets the count and the stored interval to `wdata`, visible after that clock edge. A load in a cycle that is also a tick wins over the decrement.
- R3: With control bit 7 set, each selected tick lowers the count by exactly one. With bit 7 clear, the count does not change except by a load.
- R4: With control bit 3 set, a tick falls every CLK_HZ/FAST_HZ cycles; with it clear, every CLK_HZ/SLOW_HZ cycles. Both prescalers run from reset whether or not counting is on, so ticks land on clock edges k (counted from 1 after reset release) that are multiples of the divide ratio.
- R5: When a decrement produces zero, `irq` is high for exactly one cycle, right after that edge.
- R6: With control bit 6 clear (one-shot), the count stays at 0 after expiry. The next tick wraps it to all ones without an interrupt.
- R7: With control bit 6 set (auto-reload), the count equals the stored interval in the cycle the interrupt is high.
- R8: `rdata` returns the count when `rd_sel` is 0, and the control byte zero-extended when `rd_sel` is 1. The control byte is written from `wdata[7:0]` when `cfg_we` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the control byte |
| load_we | input | 1 | Write strobe for the load value |
| wdata | input | CNT_W | Write data (control byte in bits 7:0) |
| rd_sel | input | 1 | Read select: 0 count, 1 control byte |
| rdata | output | CNT_W | Read data |
| count | output | CNT_W | Live count |
| irq | output | 1 | One-cycle expiry pulse |

## Verification
A wrong prescaler phase moves every interrupt off the edge predicted from reset, and the interrupt time-stamp scoreboard catches it on the first expiry. A stuck or mis-stepping count shows at the count port within one tick of the sample point. A bad reload or one-shot decision shows in the same cycle as the interrupt. A load that loses to the decrement reads back one less than written on the very next cycle.

// File: rtl/drt_pkg.sv
package drt_pkg;

  // Control byte layout; bit positions are software-visible.
  typedef struct packed {
    logic       run;       // bit 7: counting on
    logic       reload;    // bit 6: auto-reload on expiry
    logic [1:0] spare_hi;  // bits 5:4
    logic       fast;      // bit 3: fast tick selected
    logic [2:0] spare_lo;  // bits 2:0
  } drt_cfg_t;

  localparam int unsigned RATE_N = 2;  // index 0 slow, 1 fast

  // Divide ratio from clock and target rate, never below 1.
  function automatic int unsigned div_ratio(input int unsigned clk_hz,
                                            input int unsigned rate_hz);
    int unsigned r;
    r = (rate_hz == 0) ? 1 : clk_hz / rate_hz;
    return (r < 1) ? 1 : r;
  endfunction

endpackage

// File: rtl/drt_prescale.sv
module drt_prescale #(
  parameter int unsigned DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned LIM = (DIV > 1) ? DIV - 1 : 0;
  localparam int unsigned PW  = (LIM > 0) ? $clog2(LIM + 1) : 1;

  logic [PW-1:0] phase_q;

  function automatic logic [PW-1:0] phase_next(input logic [PW-1:0] p);
    return (p == PW'(LIM)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_next(phase_q);
  end

  assign tick_o = (phase_q == PW'(LIM));
endmodule

// File: rtl/drt_rate_sel.sv
module drt_rate_sel #(
  parameter int unsigned CLK_HZ  = 100_000_000,
  parameter int unsigned SLOW_HZ = 2000,
  parameter int unsigned FAST_HZ = 512000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fast_i,
  output logic tick_o
);
  import drt_pkg::*;

  localparam int unsigned SLOW_DIV = div_ratio(CLK_HZ, SLOW_HZ);
  localparam int unsigned FAST_DIV = div_ratio(CLK_HZ, FAST_HZ);

  logic [RATE_N-1:0] ticks_w;

  for (genvar g = 0; g < RATE_N; g++) begin : g_rate
    localparam int unsigned THIS_DIV = (g == 0) ? SLOW_DIV : FAST_DIV;
    drt_prescale #(.DIV(THIS_DIV)) u_ps (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (ticks_w[g])
    );
  end

  assign tick_o = fast_i ? ticks_w[1] : ticks_w[0];
endmodule

// File: rtl/drt_count_core.sv
module drt_count_core #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             reload_i,
  input  logic             load_we_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] interval_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] count_q, interval_q, dec_w, after_exp_w;
  logic             step_w, expire_w, irq_q;

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v);
    return v - CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] expiry_value(input logic rl,
                                                    input logic [CNT_W-1:0] iv);
    return rl ? iv : '0;
  endfunction

  assign dec_w       = step_down(count_q);
  assign step_w      = tick_i & run_i;
  assign expire_w    = step_w & ~load_we_i & (dec_w == '0);
  assign after_exp_w = expiry_value(reload_i, interval_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q    <= '0;
      interval_q <= '0;
      irq_q      <= 1'b0;
    end else begin
      irq_q <= expire_w;
      if (load_we_i) begin
        count_q    <= load_val_i;
        interval_q <= load_val_i;
      end else if (step_w) begin
        count_q <= expire_w ? after_exp_w : dec_w;
      end
    end
  end

  assign count_o    = count_q;
  assign interval_o = interval_q;
  assign irq_o      = irq_q;
endmodule

// File: rtl/drt_regs.sv
module drt_regs #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we_i,
  input  logic [7:0]       cfg_wdata_i,
  input  logic             rd_sel_i,
  input  logic [CNT_W-1:0] count_i,
  output drt_pkg::drt_cfg_t cfg_o,
  output logic [CNT_W-1:0] rdata_o
);
  drt_pkg::drt_cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cfg_q <= '0;
    else if (cfg_we_i) cfg_q <= drt_pkg::drt_cfg_t'(cfg_wdata_i);
  end

  assign cfg_o   = cfg_q;
  assign rdata_o = rd_sel_i ? CNT_W'(cfg_q) : count_i;
endmodule

// File: rtl/dual_rate_timer.sv
module dual_rate_timer #(
  parameter int unsigned CLK_HZ  = 100_000_000,
  parameter int unsigned SLOW_HZ = 2000,
  parameter int unsigned FAST_HZ = 512000,
  parameter int unsigned CNT_W   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             load_we,
  input  logic [CNT_W-1:0] wdata,
  input  logic             rd_sel,
  output logic [CNT_W-1:0] rdata,
  output logic [CNT_W-1:0] count,
  output logic             irq
);
  drt_pkg::drt_cfg_t cfg_w;
  logic [7:0]        cfg_bits_w;
  logic              tick_w;
  logic [CNT_W-1:0]  interval_w;

  assign cfg_bits_w = cfg_w;

  drt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we_i    (cfg_we),
    .cfg_wdata_i (wdata[7:0]),
    .rd_sel_i    (rd_sel),
    .count_i     (count),
    .cfg_o       (cfg_w),
    .rdata_o     (rdata)
  );

  drt_rate_sel #(.CLK_HZ(CLK_HZ), .SLOW_HZ(SLOW_HZ), .FAST_HZ(FAST_HZ)) u_rate (
    .clk    (clk),
    .rst_n  (rst_n),
    .fast_i (cfg_w.fast),
    .tick_o (tick_w)
  );

  drt_count_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_w),
    .run_i      (cfg_w.run),
    .reload_i   (cfg_w.reload),
    .load_we_i  (load_we),
    .load_val_i (wdata),
    .count_o    (count),
    .interval_o (interval_w),
    .irq_o      (irq)
  );
endmodule

// File: rtl/drt_chk.sv
module drt_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_we,
  input logic [CNT_W-1:0] wdata,
  input logic [7:0]       cfg_bits,
  input logic             tick,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] interval,
  input logic             irq
);
  // R2
  load_sets_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_we |=> (count == $past(wdata)));

  // R3
  halted_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_we && !cfg_bits[7]) |=> $stable(count));

  // R5
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R5
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(tick && cfg_bits[7] && !load_we));

  // R7
  reload_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && $past(cfg_bits[6])) |-> (count == interval));

  // R6
  oneshot_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !$past(cfg_bits[6])) |-> (count == '0));
endmodule

bind dual_rate_timer drt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .load_we  (load_we),
  .wdata    (wdata),
  .cfg_bits (cfg_bits_w),
  .tick     (tick_w),
  .count    (count),
  .interval (interval_w),
  .irq      (irq)
);

// File: tb/sim_dual_rate_timer.sv
`timescale 1ns/1ps
module sim_dual_rate_timer;
  localparam int unsigned CLK_HZ  = 5_120_000;
  localparam int unsigned SLOW_HZ = 2000;
  localparam int unsigned FAST_HZ = 512000;
  localparam int unsigned W       = 16;
  localparam int FD = CLK_HZ / FAST_HZ;   // 10
  localparam int SD = CLK_HZ / SLOW_HZ;   // 2560

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_we = 1'b0, load_we = 1'b0, rd_sel = 1'b0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata, count;
  logic         irq;

  int vectors = 0, miscompares = 0;
  int ecnt = 0;
  int exp_q[$];
  bit prev_irq = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  dual_rate_timer #(.CLK_HZ(CLK_HZ), .SLOW_HZ(SLOW_HZ), .FAST_HZ(FAST_HZ),
                    .CNT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .load_we(load_we),
    .wdata(wdata), .rd_sel(rd_sel), .rdata(rdata), .count(count), .irq(irq)
  );

  always @(posedge clk) if (rst_n) ecnt <= ecnt + 1;

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h (edge %0d)", req, act, exp, ecnt);
    end
  endtask

  // Monitor: each observed pulse is matched against the next expected stamp.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (irq) begin
        chk("R5 pulse width", int'(prev_irq), 0);
        if (exp_q.size() == 0) chk("R5 unexpected irq", ecnt, -1);
        else chk("R5 irq edge", ecnt, exp_q.pop_front());
      end
      prev_irq = irq;
    end
  end

  task automatic wait_to(input int n);
    while (ecnt < n) @(negedge clk);
  endtask

  task automatic align(input int m, input int d);
    @(negedge clk);
    while ((ecnt % d) != m) @(negedge clk);
  endtask

  task automatic do_load(input int v, output int at);
    @(negedge clk);
    load_we = 1'b1; wdata = W'(v);
    @(negedge clk);
    load_we = 1'b0;
    at = ecnt;
  endtask

  task automatic do_cfg(input int v, output int at);
    @(negedge clk);
    cfg_we = 1'b1; wdata = W'(v);
    @(negedge clk);
    cfg_we = 1'b0;
    at = ecnt;
  endtask

  function automatic int next_tick(input int e, input int d);
    return (e / d + 1) * d;
  endfunction

  initial begin
    int e, t0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 count", int'(count), 0);
    chk("R1 irq", int'(irq), 0);
    rd_sel = 1'b1; #0.1;
    chk("R1 cfg readback", int'(rdata), 0);
    rd_sel = 1'b0;

    // One-shot, fast rate
    align(1, FD);
    do_load(5, e);
    chk("R2 load value", int'(count), 5);
    do_cfg(8'h88, e);
    t0 = next_tick(e, FD);
    exp_q.push_back(t0 + 4*FD);
    wait_to(t0 + FD);
    chk("R3 decrement", int'(count), 3);
    chk("R8 count readback", int'(rdata), 3);
    wait_to(t0 + 4*FD);
    chk("R6 rest at zero", int'(count), 0);
    wait_to(t0 + 5*FD - 1);
    chk("R6 held zero", int'(count), 0);
    wait_to(t0 + 5*FD);
    chk("R6 wrap", int'(count), 16'hFFFF);

    // Halted
    do_cfg(8'h08, e);
    repeat (35) @(negedge clk);
    chk("R3 halted", int'(count), 16'hFFFF);
    rd_sel = 1'b1; #0.1;
    chk("R8 cfg readback", int'(rdata), 8'h08);
    rd_sel = 1'b0;

    // Auto-reload, phase kept from reset across the halt (R4)
    align(1, FD);
    do_load(3, e);
    do_cfg(8'hC8, e);
    t0 = next_tick(e, FD);
    for (int k = 0; k < 3; k++) exp_q.push_back(t0 + 2*FD + k*3*FD);
    wait_to(t0);
    chk("R4 fast phase", int'(count), 2);
    wait_to(t0 + 2*FD);
    chk("R7 reload 1", int'(count), 3);
    wait_to(t0 + 5*FD);
    chk("R7 reload 2", int'(count), 3);
    wait_to(t0 + 8*FD);
    chk("R7 reload 3", int'(count), 3);
    rd_sel = 1'b1; #0.1;
    chk("R8 cfg readback 2", int'(rdata), 8'hC8);
    rd_sel = 1'b0;
    do_cfg(8'h08, e);

    // Load on a tick edge beats the decrement
    do_load(100, e);
    do_cfg(8'h88, e);
    align(FD - 1, FD);
    do_load(7, e);
    chk("R2 load priority", int'(count), 7);
    wait_to(e + FD);
    chk("R3 after priority load", int'(count), 6);
    do_cfg(8'h08, e);

    // Slow rate, one-shot
    do_load(2, e);
    do_cfg(8'h80, e);
    t0 = next_tick(e, SD);
    exp_q.push_back(t0 + SD);
    wait_to(e + 3*FD);
    chk("R4 slow ignores fast", int'(count), 2);
    wait_to(t0 - 1);
    chk("R4 slow before tick", int'(count), 2);
    wait_to(t0);
    chk("R4 slow tick", int'(count), 1);
    wait_to(t0 + SD);
    chk("R6 slow expiry", int'(count), 0);
    do_cfg(8'h00, e);
    repeat (5) @(negedge clk);

    while (exp_q.size() > 0) chk("R5 missing irq", -1, exp_q.pop_front());
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      vectors++; miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule